// File: doc/BRIEF.md
# Process Context Switch Sequencer

This block carries out the privileged call that swaps one process context for another. When started, it writes every field of the live process context to the context block at the current base address, one memory word per request. It then reads the full incoming context from the block whose address arrives on the argument-register input. The incoming words are staged in a holding buffer and take effect together, in the same cycle as the active base pointer moves to the new block.

After the swap, the sequencer uses a request/acknowledge handshake for each side effect. It first clears the load-locked reservation, then flushes the per-process decode caches. If the incoming address-space number was last validated under an older epoch, it also asks for all non-global translation entries to be invalidated, and records the current epoch for that number. A one-cycle completion pulse ends the call.

Top module: `ctx_switch_seq`

## Requirements
- R1: A start accepted while idle first issues NF (11) write requests and then NF read requests. The writes go to `base + 8*i` with data equal to context field i, for i = 0..10 in rising order. The reads come from `arg + 8*i`, where `arg` is the argument value sampled at start. Field order is: four stack pointers (kernel, exec, supervisor, user), four trap registers, FP enable, page-table base, address-space number.
- R2: At most one memory request is outstanding at a time. While `mem_req_o` is high and not acknowledged, its address, direction and write data hold steady.
- R3: `ctx_o` and `pcb_base_o` keep their old values through every load. On the last load acknowledge they change together: `pcb_base_o` becomes `arg`, and field i of `ctx_o` (bits 64*i+63..64*i) becomes the word read for field i.
- R4: Every switch raises `rsv_clr_req_o` exactly once, after the last load. The request is held until acknowledged.
- R5: Every switch raises `flush_req_o` exactly once, after the reservation clear is acknowledged. The request is held until acknowledged.
- R6: After the flush acknowledge, `tlb_inv_req_o` is raised once only if the stored epoch for the incoming address-space number (low 6 bits of field 10) differs from `global_epoch_i`. Otherwise no invalidation is requested.
- R7: An acknowledged invalidation stores `global_epoch_i` as the epoch of that address-space number. A later switch to the same number under the same epoch then issues no invalidation.
- R8: `busy_o` is high from the cycle after an accepted start until the done cycle. `done_o` is a single-cycle pulse that comes after every load and every side-effect acknowledge.
- R9: A start request while busy is ignored. It starts no second sequence and does not change the target address.
- R10: After reset, every request output and `busy_o`/`done_o` are low, `pcb_base_o` and `ctx_o` are zero, and every stored epoch is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a context switch |
| arg16_i | input | AW | Incoming context block address |
| global_epoch_i | input | EPOCH_W | Current global address-space epoch |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| rsv_clr_req_o | output | 1 | Clear load-locked reservation |
| rsv_clr_ack_i | input | 1 | Reservation clear done |
| flush_req_o | output | 1 | Flush per-process decode caches |
| flush_ack_i | input | 1 | Flush done |
| tlb_inv_req_o | output | 1 | Invalidate non-global translations |
| tlb_inv_ack_i | input | 1 | Invalidation done |
| pcb_base_o | output | AW | Active context block base |
| ctx_o | output | NF*DW | Live process context, field i at bits 64*i+63..64*i |

## Verification
The bench varies memory latency to show that addresses stay steady while an acknowledge is pending; a design that advanced early would skip or duplicate words. It watches the base pointer during the load phase, because a design that committed piecemeal would expose a half-loaded context. Epoch handling is exercised across a run of switches: a fresh epoch must force an invalidation, a repeat must not, and a design that never recorded the epoch would invalidate on every switch. A second start pulse in mid-sequence checks that a busy sequencer does not restart or retarget to the new address.

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int ASN_W   = 6,
  parameter int EPOCH_W = 8,
  parameter int NF      = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [AW-1:0]      arg16_i,
  input  logic [EPOCH_W-1:0] global_epoch_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               rsv_clr_req_o,
  input  logic               rsv_clr_ack_i,
  output logic               flush_req_o,
  input  logic               flush_ack_i,
  output logic               tlb_inv_req_o,
  input  logic               tlb_inv_ack_i,
  output logic [AW-1:0]      pcb_base_o,
  output logic [NF*DW-1:0]   ctx_o
);
  localparam int IW      = $clog2(NF);
  localparam int SH      = $clog2(DW/8);
  localparam int NASN    = 1 << ASN_W;
  localparam int ASN_FLD = NF - 1;

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_LOAD, S_RSV, S_FLUSH, S_TLB, S_DONE} st_t;

  st_t                      state;
  logic [IW-1:0]            idx;
  logic [AW-1:0]            in_base, base_q;
  logic [NF-1:0][DW-1:0]    ctx_q, shadow;
  logic [EPOCH_W-1:0]       epoch_tab [NASN];

  wire             last    = (idx == IW'(NF - 1));
  wire [ASN_W-1:0] cur_asn = ctx_q[ASN_FLD][ASN_W-1:0];
  wire             stale   = (epoch_tab[cur_asn] != global_epoch_i);

  assign busy_o        = (state != S_IDLE);
  assign done_o        = (state == S_DONE);
  assign mem_req_o     = (state == S_SAVE) || (state == S_LOAD);
  assign mem_we_o      = (state == S_SAVE);
  assign mem_addr_o    = (mem_we_o ? base_q : in_base) + (AW'(idx) << SH);
  assign mem_wdata_o   = ctx_q[idx];
  assign rsv_clr_req_o = (state == S_RSV);
  assign flush_req_o   = (state == S_FLUSH);
  assign tlb_inv_req_o = (state == S_TLB);
  assign pcb_base_o    = base_q;
  assign ctx_o         = ctx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      in_base <= '0;
      base_q  <= '0;
      ctx_q   <= '0;
      shadow  <= '0;
      for (int a = 0; a < NASN; a++) epoch_tab[a] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          in_base <= arg16_i;
          idx     <= '0;
          state   <= S_SAVE;
        end
        S_SAVE: if (mem_ack_i) begin
          if (last) begin
            idx   <= '0;
            state <= S_LOAD;
          end else idx <= idx + 1'b1;
        end
        S_LOAD: if (mem_ack_i) begin
          shadow[idx] <= mem_rdata_i;
          if (last) begin
            for (int f = 0; f < NF; f++)
              ctx_q[f] <= (f == NF - 1) ? mem_rdata_i : shadow[f];
            base_q <= in_base;
            idx    <= '0;
            state  <= S_RSV;
          end else idx <= idx + 1'b1;
        end
        S_RSV:   if (rsv_clr_ack_i) state <= S_FLUSH;
        S_FLUSH: if (flush_ack_i) state <= stale ? S_TLB : S_DONE;
        S_TLB: if (tlb_inv_ack_i) begin
          epoch_tab[cur_asn] <= global_epoch_i;
          state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_LOAD) |=> $stable(pcb_base_o) && $stable(ctx_o));

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && mem_ack_i && last) |=> (pcb_base_o == $past(in_base)));

  p_rsv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_clr_req_o && !rsv_clr_ack_i) |=> rsv_clr_req_o);

  p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_o && !flush_ack_i) |=> flush_req_o);

  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, rsv_clr_req_o, flush_req_o, tlb_inv_req_o}));

  p_epoch_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_inv_req_o && tlb_inv_ack_i) |=> (epoch_tab[cur_asn] == $past(global_epoch_i)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_busy_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(in_base));
endmodule

// File: tb/ctx_switch_seq_test.sv
`timescale 1ns/1ps
module ctx_switch_seq_test;
  localparam int NF = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] arg16 = '0;
  logic [7:0]  gepoch = '0;
  logic        busy, done;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        rsv_req, rsv_ack = 1'b0;
  logic        fl_req, fl_ack = 1'b0;
  logic        tlb_req, tlb_ack = 1'b0;
  logic [31:0] pcb_base;
  logic [NF*64-1:0] ctx;

  always #2.5 clk = ~clk;

  ctx_switch_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .arg16_i(arg16), .global_epoch_i(gepoch),
    .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsv_clr_req_o(rsv_req), .rsv_clr_ack_i(rsv_ack),
    .flush_req_o(fl_req), .flush_ack_i(fl_ack),
    .tlb_inv_req_o(tlb_req), .tlb_inv_ack_i(tlb_ack),
    .pcb_base_o(pcb_base), .ctx_o(ctx));

  int n_tests = 0, n_fail = 0;
  logic [63:0] mem [0:127];
  int lat = 0, wcnt = 0, stamp = 0, nlog = 0;
  int n_rsv = 0, n_fl = 0, n_tlb = 0, hold_err = 0, early = 0;
  int last_mem_st = 0, rsv_st = 0, fl_st = 0, tlb_st = 0;
  bit waiting = 0;
  logic [31:0] prev_addr = '0, base_before = '0;
  logic        log_we   [0:63];
  logic [31:0] log_addr [0:63];
  logic [63:0] log_data [0:63];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (waiting && mem_addr != prev_addr) hold_err++;
      if (!mem_we && pcb_base != base_before) early++;
      if (wcnt >= lat) begin
        if (mem_we) mem[mem_addr[9:3]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:3]];
        if (nlog < 64) begin
          log_we[nlog] = mem_we; log_addr[nlog] = mem_addr; log_data[nlog] = mem_wdata;
        end
        nlog++;
        mem_ack = 1'b1; wcnt = 0; waiting = 0;
        stamp++; last_mem_st = stamp;
      end else begin
        wcnt++; waiting = 1; prev_addr = mem_addr;
      end
    end
    if (rsv_ack) rsv_ack = 1'b0;
    else if (rsv_req) begin rsv_ack = 1'b1; n_rsv++; stamp++; rsv_st = stamp; end
    if (fl_ack) fl_ack = 1'b0;
    else if (fl_req) begin fl_ack = 1'b1; n_fl++; stamp++; fl_st = stamp; end
    if (tlb_ack) tlb_ack = 1'b0;
    else if (tlb_req) begin tlb_ack = 1'b1; n_tlb++; stamp++; tlb_st = stamp; end
  end

  task automatic fill(input logic [31:0] base, input logic [63:0] asn);
    for (int i = 0; i < NF; i++) begin
      logic [6:0] w;
      w = base[9:3] + 7'(i);
      mem[w] = (i == NF - 1) ? asn : (64'h5A00_0000_0000_0000 | (64'(base) << 16) | 64'(i));
    end
  endtask

  task automatic clear_logs();
    nlog = 0; n_rsv = 0; n_fl = 0; n_tlb = 0; hold_err = 0; early = 0;
    rsv_st = 0; fl_st = 0; tlb_st = 0; last_mem_st = 0;
    base_before = pcb_base;
  endtask

  task automatic wait_done(input string tag);
    int cyc;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R8", {tag, " done pulse seen"}, done, 1'b1);
    chk("R8", {tag, " side effects before done"}, (fl_st > 0 && stamp == (n_tlb ? tlb_st : fl_st)), 1'b1);
    @(negedge clk);
    chk("R8", {tag, " done single cycle"}, done, 1'b0);
    chk("R8", {tag, " busy drops"}, busy, 1'b0);
  endtask

  task automatic do_switch(input logic [31:0] arg, input bit exp_tlb, input string tag);
    logic [31:0] old_base;
    logic [NF*64-1:0] old_ctx;
    int bad_w, bad_r, bad_c;
    old_base = pcb_base; old_ctx = ctx;
    clear_logs();
    @(negedge clk); start = 1'b1; arg16 = arg;
    @(negedge clk); start = 1'b0;
    chk("R8", {tag, " busy after start"}, busy, 1'b1);
    wait_done(tag);
    chk("R1", {tag, " request count"}, 64'(nlog), 64'(2 * NF));
    bad_w = 0; bad_r = 0; bad_c = 0;
    for (int i = 0; i < NF; i++) begin
      if (!log_we[i] || log_addr[i] != old_base + 32'(8 * i) || log_data[i] != old_ctx[i*64 +: 64]) bad_w++;
      if (log_we[NF+i] || log_addr[NF+i] != arg + 32'(8 * i)) bad_r++;
      if (ctx[i*64 +: 64] != mem[arg[9:3] + 7'(i)]) bad_c++;
    end
    chk("R1", {tag, " save writes in order"}, 64'(bad_w), 64'd0);
    chk("R1", {tag, " loads in order from arg"}, 64'(bad_r), 64'd0);
    chk("R2", {tag, " address steady while waiting"}, 64'(hold_err), 64'd0);
    chk("R3", {tag, " no commit during loads"}, 64'(early), 64'd0);
    chk("R3", {tag, " base updated"}, 64'(pcb_base), 64'(arg));
    chk("R3", {tag, " context loaded whole"}, 64'(bad_c), 64'd0);
    chk("R4", {tag, " one reservation clear"}, 64'(n_rsv), 64'd1);
    chk("R4", {tag, " clear after loads"}, (rsv_st > last_mem_st), 1'b1);
    chk("R5", {tag, " one flush"}, 64'(n_fl), 64'd1);
    chk("R5", {tag, " flush after clear"}, (fl_st > rsv_st), 1'b1);
    chk("R6", {tag, " invalidation count"}, 64'(n_tlb), 64'(exp_tlb));
    if (exp_tlb) chk("R6", {tag, " invalidation after flush"}, (tlb_st > fl_st), 1'b1);
  endtask

  task automatic t_reset();
    chk("R10", "busy", busy, 1'b0);
    chk("R10", "done", done, 1'b0);
    chk("R10", "requests", {mem_req, rsv_req, fl_req, tlb_req}, 4'b0);
    chk("R10", "base", 64'(pcb_base), 64'd0);
    chk("R10", "context", 64'(ctx == '0), 64'd1);
  endtask

  task automatic t_first();
    lat = 0; gepoch = 8'd0;
    fill(32'h200, 64'd3);
    do_switch(32'h200, 1'b0, "first(R10 epochs zero)");
  endtask

  task automatic t_stale();
    int bad;
    lat = 2; gepoch = 8'd1;
    fill(32'h300, 64'd5);
    do_switch(32'h300, 1'b1, "stale");
    bad = 0;
    for (int i = 0; i < NF; i++)
      if (mem[7'h40 + 7'(i)] != ((i == NF - 1) ? 64'd3 : (64'h5A00_0000_0000_0000 | (64'h200 << 16) | 64'(i)))) bad++;
    chk("R1", "saved image of outgoing", 64'(bad), 64'd0);
  endtask

  task automatic t_epoch();
    lat = 1;
    do_switch(32'h200, 1'b1, "back asn3 (R6)");
    do_switch(32'h300, 1'b0, "asn5 refreshed (R7)");
    gepoch = 8'd2;
    do_switch(32'h200, 1'b1, "new epoch (R7)");
  endtask

  task automatic t_busy_start();
    lat = 1;
    fill(32'h100, 64'd9);
    fill(32'h380, 64'd9);
    clear_logs();
    @(negedge clk); start = 1'b1; arg16 = 32'h100;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; arg16 = 32'h380;
    @(negedge clk); start = 1'b0;
    wait_done("busy start");
    repeat (5) @(negedge clk);
    chk("R9", "no second sequence", 64'(nlog), 64'(2 * NF));
    chk("R9", "target kept", 64'(pcb_base), 64'h100);
    chk("R9", "idle after", busy, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first();
    t_stale();
    t_epoch();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule